// File: doc/BRIEF.md
# Receive Descriptor Ownership Lookahead Controller

This block decides when a receive DMA engine may move frame data into host buffers held in a ring of descriptors. It keeps one "known owned by the controller" bit for the current descriptor and one for the next. A descriptor is read from memory only when its bit is clear. When a frame is accepted and the current descriptor is not known to be owned, the block makes one last read of it. If that read shows the host still owns it, the frame is dropped and counted as missed.

While a frame streams in, the block opens and closes the transfer window. When a buffer fills and the next descriptor is owned, it hands the full buffer back with a write that changes only the ownership bit, advances the ring, and reads ahead one descriptor further. When a buffer fills and no next buffer is available, it returns the buffer with error status and drops the rest of the frame. At end of frame it writes the end-of-packet flag and the frame byte count into the last descriptor used, then promotes the next descriptor to current.

Descriptor accesses use a valid/ready request with one access in flight. A read returns its ownership bit in the handshake cycle. An idle poll strobe from an outside timer lets ownership be refreshed between frames.

Top module: `rx_desc_own_ctrl`

## Requirements
- R1: No read is issued for a descriptor whose ownership is already known to be the controller's. When both current and next are known owned, poll strobes and frame accepts issue no reads.
- R2: A frame accept while the current descriptor is not known owned issues an immediate read (req_kind_o = 0) of the current descriptor.
- R3: If that read returns ownership 0 (host), miss_o rises and stays high until the end-of-frame pulse, the missed-frame counter increments once, and no request is issued until end of frame.
- R4: Once the current descriptor is owned, the next descriptor is read if not known owned. xfer_en_o is then asserted whatever that read returned.
- R5: A buffer-full pulse while the next descriptor is not owned issues a status write (req_kind_o = 2) to the current descriptor with wr_buff_o = 1, wr_oflo_o = oflo_i, wr_enp_o = 0. The ring advances, xfer_en_o stays low, and end of frame then writes nothing.
- R6: A buffer-full pulse while the next descriptor is owned issues an ownership-clear write (req_kind_o = 1) to the current descriptor with all status outputs zero, and the ring advances.
- R7: After an R6 release, the descriptor following the new current one is always read. Transfer then resumes whatever ownership that read returned.
- R8: An end-of-frame pulse during transfer issues a status write (kind 2) to the current descriptor with wr_enp_o = 1 and wr_cnt_o = frame_len_i. The next descriptor then becomes current.
- R9: A request holds req_valid_o, req_kind_o and req_idx_o stable until req_ready_i. Only one access is in flight. rd_own_i is taken in the handshake cycle.
- R10: The missed-frame counter is MISS_W bits wide (default 16), steps by exactly one per miss, and wraps to zero.
- R11: In idle, a poll strobe reads the current descriptor if it is not known owned. Otherwise it reads the next descriptor if that is not known owned. Each strobe issues at most one read.
- R12: After reset, current index is 0, nothing is known owned, and xfer_en_o, miss_o, req_valid_o and the counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_acc_i | input | 1 | Pulse: address filter accepted a frame |
| buf_full_i | input | 1 | Pulse: current buffer full, frame continues |
| oflo_i | input | 1 | Overflow condition, sampled with buf_full_i |
| eof_i | input | 1 | Pulse: last frame byte left the receive FIFO |
| frame_len_i | input | CNT_W | Total frame byte count, valid with eof_i |
| poll_tick_i | input | 1 | Idle poll strobe |
| req_valid_o | output | 1 | Descriptor access request |
| req_ready_i | input | 1 | Memory accepts the access |
| req_kind_o | output | 2 | 0 read, 1 ownership clear, 2 status write |
| req_idx_o | output | IDX_W | Descriptor index in the ring |
| rd_own_i | input | 1 | Ownership bit returned by a read |
| wr_enp_o | output | 1 | End-of-packet flag for status writes |
| wr_buff_o | output | 1 | Buffer error flag for status writes |
| wr_oflo_o | output | 1 | Overflow flag for status writes |
| wr_cnt_o | output | CNT_W | Frame byte count for status writes |
| xfer_en_o | output | 1 | Data transfer into the current buffer allowed |
| miss_o | output | 1 | Current frame is being missed |
| miss_cnt_o | output | MISS_W | Missed-frame counter |

## Verification
The hardest situation to reach is a frame that spans three buffers, where the block releases two descriptors and reads ahead twice while the transfer window opens and closes between steps. The bench gets there with a table of ring ownership patterns, each started from reset. Each pattern is paired with a count of buffer-full pulses that are sent only while the transfer window is open. This reaches the release-then-error path and the lookahead that finds a host-owned descriptor. A second hard case is the counter wrap, which is reached by building the bench with a narrow counter and issuing back-to-back missed frames.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    ACC_READ    = 2'd0,
    ACC_OWN_CLR = 2'd1,
    ACC_STATUS  = 2'd2
  } acc_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_TCUR, S_TNXT, S_FINAL, S_PNEXT, S_XFER,
    S_REL, S_LOOK, S_BERR, S_DROP, S_MISS, S_DONE
  } seq_state_e;
endpackage

// File: rtl/rdo_ring_state.sv
module rdo_ring_state #(
  parameter int RING_SIZE = 16,
  parameter int IDX_W     = $clog2(RING_SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_cur_i,
  input  logic             ld_nxt_i,
  input  logic             own_val_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic             cur_own_o,
  output logic             nxt_own_o
);
  logic [IDX_W-1:0] cur_q;
  logic             cur_own_q, nxt_own_q;

  assign nxt_idx_o = (cur_q == IDX_W'(RING_SIZE-1)) ? '0 : cur_q + 1'b1;
  assign cur_idx_o = cur_q;
  assign cur_own_o = cur_own_q;
  assign nxt_own_o = nxt_own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      cur_own_q <= 1'b0;
      nxt_own_q <= 1'b0;
    end else if (adv_i) begin
      cur_q     <= nxt_idx_o;
      cur_own_q <= nxt_own_q;
      nxt_own_q <= 1'b0;
    end else begin
      if (ld_cur_i) cur_own_q <= own_val_i;
      if (ld_nxt_i) nxt_own_q <= own_val_i;
    end
  end

  // R8
  ring_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (cur_idx_o == $past(nxt_idx_o)) && (cur_own_o == $past(nxt_own_o)) && !nxt_own_o);
endmodule

// File: rtl/rdo_miss_cnt.sv
module rdo_miss_cnt #(
  parameter int MISS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [MISS_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  // R10
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == MISS_W'($past(cnt_o) + 1'b1)) && $past(inc_i));
endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
  import rdo_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_acc_i,
  input  logic             buf_full_i,
  input  logic             oflo_i,
  input  logic             eof_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic             poll_tick_i,
  input  logic             cur_own_i,
  input  logic             nxt_own_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] nxt_idx_i,
  input  logic             req_ready_i,
  input  logic             rd_own_i,
  output logic             req_valid_o,
  output logic [1:0]       req_kind_o,
  output logic [IDX_W-1:0] req_idx_o,
  output logic             wr_enp_o,
  output logic             wr_buff_o,
  output logic             wr_oflo_o,
  output logic [CNT_W-1:0] wr_cnt_o,
  output logic             ld_cur_o,
  output logic             ld_nxt_o,
  output logic             adv_o,
  output logic             miss_inc_o,
  output logic             xfer_en_o,
  output logic             miss_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] len_q;
  logic             oflo_q;
  logic             hs;

  assign hs = req_valid_o && req_ready_i;

  always_comb begin
    req_valid_o = 1'b0;
    req_kind_o  = ACC_READ;
    req_idx_o   = cur_idx_i;
    unique case (state_q)
      S_TCUR, S_FINAL:        req_valid_o = 1'b1;
      S_TNXT, S_PNEXT, S_LOOK: begin req_valid_o = 1'b1; req_idx_o = nxt_idx_i; end
      S_REL:                  begin req_valid_o = 1'b1; req_kind_o = ACC_OWN_CLR; end
      S_BERR, S_DONE:         begin req_valid_o = 1'b1; req_kind_o = ACC_STATUS; end
      default: ;
    endcase
  end

  assign wr_enp_o  = (state_q == S_DONE);
  assign wr_buff_o = (state_q == S_BERR);
  assign wr_oflo_o = (state_q == S_BERR) && oflo_q;
  assign wr_cnt_o  = (state_q == S_DONE) ? len_q : '0;
  assign xfer_en_o = (state_q == S_XFER);
  assign miss_o    = (state_q == S_MISS);

  always_comb begin
    state_d    = state_q;
    ld_cur_o   = 1'b0;
    ld_nxt_o   = 1'b0;
    adv_o      = 1'b0;
    miss_inc_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (frame_acc_i)
          state_d = !cur_own_i ? S_FINAL : (nxt_own_i ? S_XFER : S_PNEXT);
        else if (poll_tick_i) begin
          if (!cur_own_i)      state_d = S_TCUR;
          else if (!nxt_own_i) state_d = S_TNXT;
        end
      end
      S_TCUR:  if (hs) begin ld_cur_o = 1'b1; state_d = S_IDLE; end
      S_TNXT:  if (hs) begin ld_nxt_o = 1'b1; state_d = S_IDLE; end
      S_FINAL: if (hs) begin
        ld_cur_o = 1'b1;
        if (rd_own_i) state_d = nxt_own_i ? S_XFER : S_PNEXT;
        else begin miss_inc_o = 1'b1; state_d = S_MISS; end
      end
      S_PNEXT: if (hs) begin ld_nxt_o = 1'b1; state_d = S_XFER; end
      S_XFER: begin
        if (eof_i)           state_d = S_DONE;
        else if (buf_full_i) state_d = nxt_own_i ? S_REL : S_BERR;
      end
      S_REL:   if (hs) begin adv_o = 1'b1; state_d = S_LOOK; end
      S_LOOK:  if (hs) begin ld_nxt_o = 1'b1; state_d = S_XFER; end
      S_BERR:  if (hs) begin adv_o = 1'b1; state_d = S_DROP; end
      S_DROP, S_MISS: if (eof_i) state_d = S_IDLE;
      S_DONE:  if (hs) begin adv_o = 1'b1; state_d = S_IDLE; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      len_q   <= '0;
      oflo_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_XFER && eof_i) len_q <= frame_len_i;
      if (state_q == S_XFER && !eof_i && buf_full_i) oflo_q <= oflo_i;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_kind_o) && $stable(req_idx_o));
  // R1
  no_known_cur_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == ACC_READ && req_idx_o == cur_idx_i) |-> !cur_own_i);
  // R1
  no_known_nxt_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == ACC_READ && req_idx_o == nxt_idx_i) |-> !nxt_own_i);
  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !req_valid_o);
  // R4
  xfer_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |-> !req_valid_o && !miss_o);
  // R6
  own_clr_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_kind_o == ACC_OWN_CLR) |-> !wr_enp_o && !wr_buff_o && !wr_oflo_o && (wr_cnt_o == '0));
endmodule

// File: rtl/rx_desc_own_ctrl.sv
module rx_desc_own_ctrl #(
  parameter int RING_SIZE = 16,
  parameter int CNT_W     = 12,
  parameter int MISS_W    = 16,
  localparam int IDX_W    = $clog2(RING_SIZE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_acc_i,
  input  logic              buf_full_i,
  input  logic              oflo_i,
  input  logic              eof_i,
  input  logic [CNT_W-1:0]  frame_len_i,
  input  logic              poll_tick_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [1:0]        req_kind_o,
  output logic [IDX_W-1:0]  req_idx_o,
  input  logic              rd_own_i,
  output logic              wr_enp_o,
  output logic              wr_buff_o,
  output logic              wr_oflo_o,
  output logic [CNT_W-1:0]  wr_cnt_o,
  output logic              xfer_en_o,
  output logic              miss_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  logic [IDX_W-1:0] cur_idx, nxt_idx;
  logic cur_own, nxt_own, ld_cur, ld_nxt, adv, miss_inc;

  rdo_ring_state #(.RING_SIZE(RING_SIZE), .IDX_W(IDX_W)) u_ring (
    .clk_i, .rst_ni,
    .ld_cur_i(ld_cur), .ld_nxt_i(ld_nxt), .own_val_i(rd_own_i), .adv_i(adv),
    .cur_idx_o(cur_idx), .nxt_idx_o(nxt_idx), .cur_own_o(cur_own), .nxt_own_o(nxt_own)
  );

  rdo_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .frame_acc_i, .buf_full_i, .oflo_i, .eof_i, .frame_len_i, .poll_tick_i,
    .cur_own_i(cur_own), .nxt_own_i(nxt_own), .cur_idx_i(cur_idx), .nxt_idx_i(nxt_idx),
    .req_ready_i, .rd_own_i,
    .req_valid_o, .req_kind_o, .req_idx_o,
    .wr_enp_o, .wr_buff_o, .wr_oflo_o, .wr_cnt_o,
    .ld_cur_o(ld_cur), .ld_nxt_o(ld_nxt), .adv_o(adv), .miss_inc_o(miss_inc),
    .xfer_en_o, .miss_o
  );

  rdo_miss_cnt #(.MISS_W(MISS_W)) u_miss (
    .clk_i, .rst_ni, .inc_i(miss_inc), .cnt_o(miss_cnt_o)
  );
endmodule

// File: tb/sim_rx_desc_own_ctrl.sv
module sim_rx_desc_own_ctrl;
  localparam int RING = 4;
  localparam int CW   = 12;
  localparam int MW   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_acc_i = 1'b0, buf_full_i = 1'b0, oflo_i = 1'b0, eof_i = 1'b0, poll_tick_i = 1'b0;
  logic [CW-1:0] frame_len_i = '0;
  logic req_valid_o, req_ready_i, rd_own_i, wr_enp_o, wr_buff_o, wr_oflo_o, xfer_en_o, miss_o;
  logic [1:0] req_kind_o, req_idx_o;
  logic [CW-1:0] wr_cnt_o;
  logic [MW-1:0] miss_cnt_o;

  always #5 clk_i = ~clk_i;

  rx_desc_own_ctrl #(.RING_SIZE(RING), .CNT_W(CW), .MISS_W(MW)) u0 (.*);

  // memory model
  logic [3:0] own_mem;
  logic rdy = 1'b1;
  int reads [4];
  int nwr;
  logic [1:0] lw_idx;
  logic lw_enp, lw_buff, lw_oflo;
  logic [CW-1:0] lw_cnt;
  assign req_ready_i = rdy;
  assign rd_own_i = own_mem[req_idx_o];

  always @(posedge clk_i) begin
    if (rst_ni && req_valid_o && rdy) begin
      if (req_kind_o == 2'd0) reads[req_idx_o] <= reads[req_idx_o] + 1;
      else begin
        own_mem[req_idx_o] <= 1'b0;
        nwr    <= nwr + 1;
        lw_idx <= req_idx_o;
        lw_enp <= wr_enp_o; lw_buff <= wr_buff_o; lw_oflo <= wr_oflo_o; lw_cnt <= wr_cnt_o;
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int total_reads();
    return reads[0] + reads[1] + reads[2] + reads[3];
  endfunction

  task automatic do_reset(logic [3:0] own);
    @(negedge clk_i);
    rst_ni = 1'b0;
    frame_acc_i = 0; buf_full_i = 0; eof_i = 0; poll_tick_i = 0; oflo_i = 0; rdy = 1'b1;
    own_mem = own; nwr = 0; lw_idx = 0; lw_enp = 0; lw_buff = 0; lw_oflo = 0; lw_cnt = 0;
    for (int k = 0; k < 4; k++) reads[k] = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic pulse_acc(); frame_acc_i = 1; @(negedge clk_i); frame_acc_i = 0; endtask
  task automatic pulse_tick(); poll_tick_i = 1; @(negedge clk_i); poll_tick_i = 0; repeat (3) @(negedge clk_i); endtask
  task automatic pulse_eof(logic [CW-1:0] len);
    frame_len_i = len; eof_i = 1; @(negedge clk_i); eof_i = 0;
  endtask
  task automatic pulse_full(logic ov);
    oflo_i = ov; buf_full_i = 1; @(negedge clk_i); buf_full_i = 0; oflo_i = 0;
  endtask
  task automatic wait_xfer();
    for (int t = 0; t < 20 && !xfer_en_o; t++) @(negedge clk_i);
  endtask

  typedef struct packed {
    logic [3:0] own; logic [1:0] nfull; logic oflo; logic [11:0] len;
    logic miss; logic [3:0] own_e; logic [1:0] nwr; logic [1:0] lidx;
    logic enp; logic buff; logic oflo_e; logic [11:0] cnt_e; logic xfer;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b1111, 2'd0, 1'b0, 12'd100, 1'b0, 4'b1110, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 12'd100, 1'b1},
    '{4'b0000, 2'd0, 1'b0, 12'd40,  1'b1, 4'b0000, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0,   1'b0},
    '{4'b0001, 2'd1, 1'b1, 12'd60,  1'b0, 4'b0000, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 12'd0,   1'b1},
    '{4'b0111, 2'd1, 1'b0, 12'd300, 1'b0, 4'b0100, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 12'd300, 1'b1},
    '{4'b0011, 2'd2, 1'b0, 12'd90,  1'b0, 4'b0000, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 12'd0,   1'b1},
    '{4'b1111, 2'd2, 1'b0, 12'd500, 1'b0, 4'b1000, 2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 12'd500, 1'b1},
    '{4'b0010, 2'd0, 1'b0, 12'd50,  1'b1, 4'b0010, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 12'd0,   1'b0},
    '{4'b0011, 2'd1, 1'b0, 12'd77,  1'b0, 4'b0000, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 12'd77,  1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    do_reset(4'b1111);
    chk("R12 xfer_en", xfer_en_o, 0);
    chk("R12 req_valid", req_valid_o, 0);
    chk("R12 miss", miss_o, 0);
    chk("R12 miss_cnt", miss_cnt_o, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      bit xs;
      do_reset(VECS[i].own);
      pulse_acc();
      for (int t = 0; t < 20 && !xfer_en_o && !miss_o; t++) @(negedge clk_i);
      xs = xfer_en_o;
      chk($sformatf("R4 vec%0d xfer", i), xs, VECS[i].xfer);
      for (int k = 0; k < int'(VECS[i].nfull); k++) begin
        wait_xfer();
        if (xfer_en_o) pulse_full(VECS[i].oflo);
      end
      repeat (10) @(negedge clk_i);
      pulse_eof(VECS[i].len);
      repeat (10) @(negedge clk_i);
      chk($sformatf("R3 vec%0d miss_cnt", i), miss_cnt_o, VECS[i].miss);
      chk($sformatf("R6 vec%0d own_mem", i), own_mem, VECS[i].own_e);
      chk($sformatf("R8 vec%0d writes", i), nwr, VECS[i].nwr);
      if (VECS[i].nwr != 0) begin
        chk($sformatf("R8 vec%0d last idx", i), lw_idx, VECS[i].lidx);
        chk($sformatf("R8 vec%0d enp", i), lw_enp, VECS[i].enp);
        chk($sformatf("R5 vec%0d buff", i), lw_buff, VECS[i].buff);
        chk($sformatf("R5 vec%0d oflo", i), lw_oflo, VECS[i].oflo_e);
        chk($sformatf("R8 vec%0d cnt", i), lw_cnt, VECS[i].cnt_e);
      end
    end

    // R11 idle polling, R1 no re-read once known
    do_reset(4'b1111);
    pulse_tick();
    chk("R11 tick reads cur", reads[0], 1);
    pulse_tick();
    chk("R11 tick reads next", reads[1], 1);
    pulse_tick();
    chk("R1 no read when both known", total_reads(), 2);
    pulse_acc();
    wait_xfer();
    chk("R1 accept issues no read", total_reads(), 2);
    chk("R4 xfer open", xfer_en_o, 1);
    pulse_eof(12'd64);
    repeat (4) @(negedge clk_i);
    chk("R8 eof idx0", lw_idx, 0);
    pulse_tick();
    chk("R11 after advance reads idx2", reads[2], 1);
    chk("R1 promoted cur not reread", reads[1], 1);

    // R3 no re-poll during miss
    do_reset(4'b0000);
    pulse_acc();
    repeat (3) @(negedge clk_i);
    chk("R3 miss_o high", miss_o, 1);
    chk("R2 final poll once", reads[0], 1);
    pulse_tick();
    pulse_tick();
    chk("R3 no poll in miss", total_reads(), 1);
    chk("R3 req idle in miss", req_valid_o, 0);
    own_mem[0] = 1'b1;
    pulse_eof(12'd10);
    @(negedge clk_i);
    chk("R3 miss_o low after eof", miss_o, 0);
    pulse_tick();
    chk("R11 repoll after miss", reads[0], 2);

    // R7 lookahead read with host-owned result, transfer continues
    do_reset(4'b0011);
    pulse_acc();
    wait_xfer();
    pulse_full(1'b0);
    wait_xfer();
    chk("R7 lookahead read idx2", reads[2], 1);
    chk("R7 xfer resumes", xfer_en_o, 1);
    chk("R6 own clear kind", nwr, 1);

    // R9 stalled handshake
    do_reset(4'b1111);
    rdy = 1'b0;
    pulse_acc();
    repeat (4) @(negedge clk_i);
    chk("R9 valid held", req_valid_o, 1);
    chk("R9 idx held", req_idx_o, 0);
    chk("R9 kind read", req_kind_o, 0);
    chk("R9 no xfer while stalled", xfer_en_o, 0);
    rdy = 1'b1;
    wait_xfer();
    chk("R9 reads after release", total_reads(), 2);

    // R10 wrap with narrow counter
    do_reset(4'b0000);
    for (int m = 0; m < 16; m++) begin
      pulse_acc();
      repeat (3) @(negedge clk_i);
      pulse_eof(12'd1);
      @(negedge clk_i);
      if (m == 14) chk("R10 count 15", miss_cnt_o, 15);
    end
    chk("R10 wrap to zero", miss_cnt_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule